// File: doc/BRIEF.md
# Pixel Bus to Packet Stream Bridge

This block takes a free-running pixel bus and turns it into a valid/ready packet stream. Each frame becomes one packet. A pixel counts only on cycles where its enable is high. The bus marks the first active pixel of a frame with a frame-start flag and the final active pixel with a frame-last flag. Output beats therefore appear only on cycles that carried active pixels, so how often `out_valid` is high follows the ratio of pixel rate to clock rate. The block is meant to be throttled by its input data rate, not by the sink.

The pixel bus cannot be stalled. A small FIFO, with a registered output stage, absorbs short stretches of low `out_ready`. If the sink holds off long enough to fill the buffer, the block drops the pixel that does not fit and closes the frame early. It does this by flagging the newest stored beat of that frame as end-of-packet. It then ignores the bus until the next frame start.

Each such event sets a sticky overflow bit. Software reads it through a one-register port, and the read clears the bit. The design uses one clock and a synchronous active-high reset. `FIFO_DEPTH` must be at least 2.

Top module: `vid_to_stream`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` is 0. `reg_rdata` reads 0 after reset.
- R2: Every accepted pixel leaves as exactly one beat, in arrival order, with `out_data` equal to `pix_data`. No beat is produced without a corresponding pixel.
- R3: The beat of a frame-start pixel (`pix_de`=1, `pix_sof`=1) has `out_sop`=1, and no other beat does. The beat of a pixel with `pix_last`=1 has `out_eop`=1. A frame of one pixel (start and last together) gives one beat with both flags set.
- R4: Pixels that arrive while no frame is open are discarded. This covers pixels before the first frame start, and pixels after a frame's last pixel and before the next start.
- R5: While `out_valid`=1 and `out_ready`=0, the beat (`out_data`, `out_sop`, `out_eop`) and `out_valid` hold unchanged into the next cycle.
- R6: The bridge stores up to `FIFO_DEPTH`+1 beats, counting the output register. The full test runs on every pixel cycle. A pixel that arrives when `FIFO_DEPTH` beats wait behind a held output beat is dropped, and this is an overflow. From an empty bridge with `out_ready` held low, exactly `FIFO_DEPTH`+1 pixels of a frame are kept.
- R7: On an overflow inside an open frame, the newest beat already stored for that frame gets `out_eop`=1. The rest of that frame is discarded. The next frame-start pixel opens a new packet with `out_sop`=1.
- R8: An overflow sets a sticky bit. A pulse on `reg_rd` places the bit on `reg_rdata[0]` one cycle later and clears it. An overflow in the same cycle as the read keeps the bit set. The upper bits of `reg_rdata` are 0.
- R9: A frame-start pixel that arrives when the bridge is full is dropped and counts as an overflow. No beat of that frame is produced, and no earlier packet is changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_data | input | DATA_W | Pixel value |
| pix_de | input | 1 | Pixel enable, high on active pixels |
| pix_sof | input | 1 | First active pixel of a frame |
| pix_last | input | 1 | Final active pixel of a frame |
| out_data | output | DATA_W | Beat payload |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Sink accepts the beat |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Final beat of a packet |
| reg_rd | input | 1 | Status register read strobe |
| reg_rdata | output | REG_W | Status read data, bit 0 is the overflow flag |

## Verification
The bench drives a stalled sink into an empty bridge and checks that exactly depth-plus-one pixels survive. A design with an off-by-one in the full test would keep one beat too many or too few. It also checks that the last kept beat carries end-of-packet; without this the packet would stay open and merge with the next frame. Two more directed cases cover a frame start that arrives at a full bridge and a status read that lands on the overflow cycle. A design that got either wrong would emit a stray start beat or lose the sticky flag. Long random runs with bursts of low ready compare every beat against a model of the bridge occupancy. That comparison catches dropped, duplicated or reordered pixels and start flags placed in the wrong spot.

// File: rtl/vts_pkg.sv
`timescale 1ns/1ps
package vts_pkg;
  // Writer side: hunting for a frame start, or passing an open frame
  typedef enum logic {
    WR_HUNT = 1'b0,
    WR_PASS = 1'b1
  } wr_state_e;
endpackage

// File: rtl/vts_writer.sv
`timescale 1ns/1ps
module vts_writer
  import vts_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pix_de,
  input  logic pix_sof,
  input  logic pix_last,
  input  logic fifo_full,
  output logic wr_en,
  output logic wr_sop,
  output logic wr_eop,
  output logic mark_eop,
  output logic ovf
);
  wr_state_e state_q;
  logic      take;

  // A pixel belongs to a packet if a frame is open or it opens one
  assign take     = pix_de && ((state_q == WR_PASS) || pix_sof);
  assign ovf      = take && fifo_full;
  assign wr_en    = take && !fifo_full;
  assign wr_sop   = (state_q == WR_HUNT);
  assign wr_eop   = pix_last;
  // Truncation only applies when the frame already has stored beats
  assign mark_eop = ovf && (state_q == WR_PASS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WR_HUNT;
    end else if (take) begin
      state_q <= (ovf || pix_last) ? WR_HUNT : WR_PASS;
    end
  end
endmodule

// File: rtl/vts_fifo.sv
`timescale 1ns/1ps
module vts_fifo #(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_sop,
  input  logic              wr_eop,
  input  logic              mark_eop,
  output logic              full,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  // Payload and start flag live in RAM; end flags stay in flops so the
  // newest entry can be patched on truncation
  logic [DATA_W:0]   ram [DEPTH];
  logic [DEPTH-1:0]  eop_f;
  logic [AW-1:0]     wr_ptr, rd_ptr, newest_ptr;
  logic [CW-1:0]     count;
  logic              pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full       = (count == CW'(DEPTH));
  assign pop        = (count != '0) && (!out_valid || out_ready);
  assign newest_ptr = (wr_ptr == '0) ? AW'(DEPTH - 1) : wr_ptr - 1'b1;

  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_ptr] <= {wr_sop, wr_data};
  end

  always_ff @(posedge clk) begin
    if (pop) {out_sop, out_data} <= ram[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      eop_f     <= '0;
      out_valid <= 1'b0;
      out_eop   <= 1'b0;
    end else begin
      if (wr_en) begin
        wr_ptr         <= bump(wr_ptr);
        eop_f[wr_ptr]  <= wr_eop;
      end
      if (mark_eop) eop_f[newest_ptr] <= 1'b1;
      if (pop) begin
        rd_ptr  <= bump(rd_ptr);
        out_eop <= eop_f[rd_ptr];
      end
      count <= count + CW'(wr_en) - CW'(pop);
      if (pop)            out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vid_to_stream.sv
`timescale 1ns/1ps
module vid_to_stream #(
  parameter int DATA_W     = 24,
  parameter int FIFO_DEPTH = 8,
  parameter int REG_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              pix_de,
  input  logic              pix_sof,
  input  logic              pix_last,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sop,
  output logic              out_eop,
  input  logic              reg_rd,
  output logic [REG_W-1:0]  reg_rdata
);
  logic wr_en, wr_sop, wr_eop, mark_eop, fifo_full, ovf_evt;
  logic sticky_q;

  vts_writer u_writer (
    .clk      (clk),
    .rst      (rst),
    .pix_de   (pix_de),
    .pix_sof  (pix_sof),
    .pix_last (pix_last),
    .fifo_full(fifo_full),
    .wr_en    (wr_en),
    .wr_sop   (wr_sop),
    .wr_eop   (wr_eop),
    .mark_eop (mark_eop),
    .ovf      (ovf_evt)
  );

  vts_fifo #(
    .DATA_W(DATA_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (pix_data),
    .wr_sop   (wr_sop),
    .wr_eop   (wr_eop),
    .mark_eop (mark_eop),
    .full     (fifo_full),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_sop  (out_sop),
    .out_eop  (out_eop)
  );

  // Sticky overflow flag, cleared by a read unless a new overflow lands
  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q  <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_rd) reg_rdata <= REG_W'(sticky_q);
      sticky_q <= ovf_evt || (sticky_q && !reg_rd);
    end
  end
endmodule

// File: rtl/vts_checker.sv
`timescale 1ns/1ps
module vts_checker #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_sop,
  input logic              out_eop,
  input logic [DATA_W-1:0] out_data,
  input logic              reg_rd,
  input logic              ovf_evt,
  input logic              sticky_q
);
  logic in_pkt;

  always_ff @(posedge clk) begin
    if (rst)                         in_pkt <= 1'b0;
    else if (out_valid && out_ready) in_pkt <= !out_eop;
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);

  assert_hold_beat_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_sop) && $stable(out_eop)));

  assert_sop_opens_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !in_pkt) |-> out_sop);

  assert_no_sop_inside_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && in_pkt) |-> !out_sop);

  assert_sticky_set_R8: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> sticky_q);

  assert_sticky_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !ovf_evt) |=> !sticky_q);
endmodule

bind vid_to_stream vts_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_sop  (out_sop),
  .out_eop  (out_eop),
  .out_data (out_data),
  .reg_rd   (reg_rd),
  .ovf_evt  (ovf_evt),
  .sticky_q (sticky_q)
);

// File: tb/test_vid_to_stream.sv
`timescale 1ns/1ps
module test_vid_to_stream;
  localparam int DATA_W = 24;
  localparam int DEPTH  = 8;
  localparam int REG_W  = 32;
  localparam int BW     = DATA_W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DATA_W-1:0] pix_data = '0;
  logic pix_de = 0, pix_sof = 0, pix_last = 0, out_ready = 0, reg_rd = 0;
  logic [DATA_W-1:0] out_data;
  logic out_valid, out_sop, out_eop;
  logic [REG_W-1:0] reg_rdata;

  always #4 clk = ~clk;

  vid_to_stream #(.DATA_W(DATA_W), .FIFO_DEPTH(DEPTH), .REG_W(REG_W)) i_vid_to_stream (
    .clk(clk), .rst(rst), .pix_data(pix_data), .pix_de(pix_de), .pix_sof(pix_sof),
    .pix_last(pix_last), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_sop(out_sop), .out_eop(out_eop),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  int checks = 0;
  int errors = 0;
  // Model state: expected beats {sop, eop, data}, occupancy, open frame, sticky
  logic [BW-1:0] exp_q[$];
  int  occ = 0;
  bit  in_frame = 0;
  bit  sticky_m = 0;
  bit  rd_pending = 0;
  bit  rd_exp = 0;
  bit  hold_pending = 0;
  logic [BW-1:0] hold_beat;
  int  beats_seen = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle: check results of the previous cycle, drive inputs, advance model
  task automatic step(input bit de, input bit sof, input bit last,
                      input logic [DATA_W-1:0] d, input bit rdy, input bit rd);
    bit take;
    bit ovf;
    logic [BW-1:0] got;
    @(negedge clk);
    got = {out_sop, out_eop, out_data};
    if (rd_pending) chk(reg_rdata == REG_W'(rd_exp), "R8 status read", reg_rdata, REG_W'(rd_exp));
    if (hold_pending) chk(out_valid && got == hold_beat, "R5 held beat", {out_valid, got}, {1'b1, hold_beat});
    pix_de = de; pix_sof = sof; pix_last = last; pix_data = d;
    out_ready = rdy; reg_rd = rd;
    take = de && (in_frame || sof);
    ovf  = 0;
    if (take) begin
      if (occ == DEPTH + 1) begin
        ovf = 1;
        if (in_frame) exp_q[exp_q.size()-1][DATA_W] = 1'b1;
        in_frame = 0;
      end else begin
        exp_q.push_back({!in_frame, last, d});
        occ++;
        in_frame = !last;
      end
    end
    hold_pending = out_valid && !rdy;
    hold_beat    = got;
    if (out_valid && rdy) begin
      beats_seen++;
      if (exp_q.size() == 0) begin
        chk(0, "R2 R4 unexpected beat", got, '0);
      end else begin
        chk(got == exp_q[0], "R2 R3 R7 beat content", got, exp_q[0]);
        void'(exp_q.pop_front());
        occ--;
      end
    end
    rd_pending = rd;
    rd_exp     = sticky_m;
    sticky_m   = ovf || (sticky_m && !rd);
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() != 0 || out_valid) && guard < 200) begin
      step(0, 0, 0, '0, 1, 0);
      guard++;
    end
    repeat (3) step(0, 0, 0, '0, 1, 0);
  endtask

  task automatic frame(input int len, input int de_pct, input int rdy_pct, input int rd_pct);
    int i = 0;
    while (i < len) begin
      bit de;
      bit rdy;
      de  = ($urandom % 100) < de_pct;
      rdy = ($urandom % 100) < rdy_pct;
      step(de, de && i == 0, de && i == len - 1, DATA_W'($urandom), rdy,
           ($urandom % 100) < rd_pct);
      if (de) i++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(!out_valid, "R1 valid in reset", out_valid, 0);
    @(negedge clk);
    rst = 0;
    chk(!out_valid, "R1 valid after reset", out_valid, 0);
    chk(reg_rdata == '0, "R1 status after reset", reg_rdata, 0);

    // R4: active pixels with no frame open
    base = beats_seen;
    for (int i = 0; i < 6; i++) step(1, 0, i == 5, DATA_W'(i + 1), 1, 0);
    drain();
    chk(beats_seen == base, "R4 pre-frame pixels", beats_seen - base, 0);

    // R2 R3: plain frame with gaps, sink always ready
    frame(12, 60, 100, 0);
    drain();
    // R3: single-pixel frame
    step(1, 1, 1, 24'hABCDEF, 1, 0);
    drain();

    // R6 R7 R8: stalled sink from empty
    base = beats_seen;
    for (int i = 0; i < 20; i++) step(1, i == 0, i == 19, DATA_W'(24'h100 + i), 0, 0);
    drain();
    chk(beats_seen - base == DEPTH + 1, "R6 kept beats", beats_seen - base, DEPTH + 1);
    step(0, 0, 0, '0, 1, 1);
    step(0, 0, 0, '0, 1, 1);
    step(0, 0, 0, '0, 1, 0);
    // R7: the next frame opens a fresh packet
    frame(5, 100, 100, 0);
    drain();

    // R9: frame start at a full bridge
    base = beats_seen;
    for (int i = 0; i <= DEPTH; i++) step(1, i == 0, i == DEPTH, DATA_W'(24'h200 + i), 0, 0);
    for (int i = 0; i < 4; i++) step(1, i == 0, i == 3, DATA_W'(24'h300 + i), 0, 0);
    drain();
    chk(beats_seen - base == DEPTH + 1, "R9 no beats from dropped frame", beats_seen - base, DEPTH + 1);
    step(0, 0, 0, '0, 1, 1);
    step(0, 0, 0, '0, 1, 0);
    chk(reg_rdata[0] == 1'b1, "R9 overflow flagged", reg_rdata[0], 1);

    // R8: read lands on the overflow cycle, bit must survive
    for (int i = 0; i < 12; i++) step(1, i == 0, i == 11, DATA_W'(24'h400 + i), 0, i == DEPTH + 1);
    drain();
    step(0, 0, 0, '0, 1, 1);
    step(0, 0, 0, '0, 1, 0);
    chk(reg_rdata[0] == 1'b1, "R8 bit kept on same-cycle overflow", reg_rdata[0], 1);

    // Random traffic with bursty backpressure and random reads
    for (int f = 0; f < 120; f++) begin
      int len;
      len = 1 + ($urandom % 40);
      frame(len, 75, (f % 5 == 0) ? 30 : 85, 4);
      repeat ($urandom % 6) step(($urandom % 2) == 1, 0, 0, DATA_W'($urandom), 1, 0);
    end
    drain();
    chk(exp_q.size() == 0, "R2 all beats delivered", exp_q.size(), 0);
    chk(!out_valid, "R2 idle at end", out_valid, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule